// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines from local peripherals, captures their levels every clock into a source register, and gates them with a software-written enable mask. Any source that is both high and enabled is pending. A single combined interrupt output is raised while at least one source is pending.

Software talks to the block through a small byte-addressed register port. Byte offset 0 is a read-only vector: it encodes the lowest-numbered pending source so that a handler can dispatch without scanning. Byte offsets 2 and 3 are write-only and replace the low and high byte of the enable mask. Halfword and word accesses are not decoded as units. They are split into byte accesses at consecutive addresses, so a word access touches four adjacent offsets and may wrap around the 12-bit register space.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: Each of the 16 source bits takes the level of its request input at every rising clock edge; the source register has no sticky or latching behaviour.
- R2: `irq_o` is high exactly when (source AND mask) is non-zero, and follows a change of a request input or of the mask one clock edge later.
- R3: A byte read at register offset 0 returns (i+1)<<2 in bits 7:0, where i is the index of the lowest set bit of (source AND mask), and returns 0 when nothing is pending.
- R4: A byte write at offset 2 replaces mask bits 7:0; a byte write at offset 3 replaces mask bits 15:8; the other mask byte is kept.
- R5: Every offset other than 0 reads as zero (the mask is not readable back), and a write to any offset other than 2 and 3 changes nothing.
- R6: Only address bits 11:0 select the register; upper address bits are ignored, and the per-byte address addr+k is computed modulo 4096.
- R7: `size_i` 0 is a byte access, 1 a halfword (2 bytes), 2 and 3 a word (4 bytes); byte k of the access goes to or comes from offset addr+k and occupies data bits 8k+7:8k; data bits of unused lanes and of any cycle without a read read as zero.
- R8: While `rst_ni` is low the mask and source registers are cleared and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| addr_i | input | 16 | Byte address; bits 11:0 used |
| wdata_i | input | 32 | Write data, byte k in bits 8k+7:8k |
| rdata_o | output | 32 | Read data, combinational during a read strobe |
| irq_i | input | 16 | Level-sensitive interrupt requests |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the block with its defaults: 16 sources, a 16-bit bus address, a 12-bit register space and a 32-bit data path. These values place the highest vector (64) inside the byte lane. The four-lane word access can hit the mask bytes in lanes 2 and 3 from offset 0, and the wrap from offset 0xFFF to 0x000 lies within one access. Above address bit 11 there is room to check that the upper bits alias.

// File: rtl/lbic_pkg.sv
package lbic_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } acc_size_e;

  // number of byte lanes an access of this size touches
  function automatic int unsigned lane_count(acc_size_e sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/lbic_lane_dec.sv
module lbic_lane_dec
  import lbic_pkg::*;
#(
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned REG_ADDR_W = 12
) (
  input  logic                                  req_i,
  input  logic [1:0]                            size_i,
  input  logic [REG_ADDR_W-1:0]                 base_i,
  output logic [NUM_LANES-1:0][REG_ADDR_W-1:0]  lane_addr_o,
  output logic [NUM_LANES-1:0]                  lane_en_o
);

  int unsigned n_act;
  assign n_act = lane_count(acc_size_e'(size_i));

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    // wraps inside the register space
    assign lane_addr_o[k] = base_i + REG_ADDR_W'(k);
    assign lane_en_o[k]   = req_i && (k < n_act);
  end

endmodule

// File: rtl/lbic_mask_reg.sv
module lbic_mask_reg #(
  parameter int unsigned NUM_SRC    = 16,
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned REG_ADDR_W = 12,
  parameter int unsigned MASK_OFS   = 2,
  localparam int unsigned MASK_BYTES = NUM_SRC / 8,
  localparam int unsigned DATA_W     = NUM_LANES * 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_i,
  input  logic [NUM_LANES-1:0][REG_ADDR_W-1:0] lane_addr_i,
  input  logic [NUM_LANES-1:0]                 lane_en_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  output logic [NUM_SRC-1:0]                   mask_q_o,
  output logic [NUM_SRC-1:0]                   mask_nxt_o
);

  logic [NUM_SRC-1:0] mask_q;

  for (genvar j = 0; j < MASK_BYTES; j++) begin : g_mbyte
    always_comb begin
      mask_nxt_o[8*j +: 8] = mask_q[8*j +: 8];
      for (int k = 0; k < NUM_LANES; k++) begin
        if (wr_i && lane_en_i[k] &&
            lane_addr_i[k] == REG_ADDR_W'(MASK_OFS + j))
          mask_nxt_o[8*j +: 8] = wdata_i[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_nxt_o;
  end

  assign mask_q_o = mask_q;

endmodule

// File: rtl/lbic_src_sync.sv
module lbic_src_sync #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] mask_nxt_i,
  output logic [NUM_SRC-1:0] src_q_o,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] src_q;
  logic               irq_q;

  // combined output uses next-state values so it stays coherent with src_q & mask_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      irq_q <= 1'b0;
    end else begin
      src_q <= irq_i;
      irq_q <= |(irq_i & mask_nxt_i);
    end
  end

  assign src_q_o = src_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/lbic_prio_enc.sv
module lbic_prio_enc #(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [7:0]         vec_o
);

  logic             found;
  logic [IDX_W-1:0] idx;
  logic [7:0]       code;

  // scan downward so the lowest index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign code  = 8'(idx) + 8'd1;
  assign vec_o = found ? (code << 2) : 8'd0;

endmodule

// File: rtl/lbic_rd_mux.sv
module lbic_rd_mux #(
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned REG_ADDR_W = 12,
  parameter int unsigned VEC_OFS    = 0
) (
  input  logic                                 rd_i,
  input  logic [NUM_LANES-1:0][REG_ADDR_W-1:0] lane_addr_i,
  input  logic [NUM_LANES-1:0]                 lane_en_i,
  input  logic [7:0]                           vec_i,
  output logic [NUM_LANES*8-1:0]               rdata_o
);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_rlane
    assign rdata_o[8*k +: 8] =
      (rd_i && lane_en_i[k] && lane_addr_i[k] == REG_ADDR_W'(VEC_OFS)) ? vec_i : 8'd0;
  end

endmodule

// File: rtl/lbus_irq_ctrl.sv
module lbus_irq_ctrl #(
  parameter int unsigned NUM_SRC    = 16,
  parameter int unsigned BUS_ADDR_W = 16,
  parameter int unsigned REG_ADDR_W = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned VEC_OFS    = 0,
  parameter int unsigned MASK_OFS   = 2,
  localparam int unsigned NUM_LANES = DATA_W / 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [1:0]            size_i,
  input  logic [BUS_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_SRC-1:0]    irq_i,
  output logic                  irq_o
);

  logic [NUM_LANES-1:0][REG_ADDR_W-1:0] lane_addr;
  logic [NUM_LANES-1:0]                 lane_en;
  logic [NUM_SRC-1:0]                   mask_q, mask_nxt, src_q, pend;
  logic [7:0]                           vec;
  logic                                 unused_hi_addr;

  assign unused_hi_addr = ^addr_i[BUS_ADDR_W-1:REG_ADDR_W];

  lbic_lane_dec #(
    .NUM_LANES (NUM_LANES),
    .REG_ADDR_W(REG_ADDR_W)
  ) u_lane_dec (
    .req_i      (req_i),
    .size_i     (size_i),
    .base_i     (addr_i[REG_ADDR_W-1:0]),
    .lane_addr_o(lane_addr),
    .lane_en_o  (lane_en)
  );

  lbic_mask_reg #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LANES (NUM_LANES),
    .REG_ADDR_W(REG_ADDR_W),
    .MASK_OFS  (MASK_OFS)
  ) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i),
    .lane_addr_i(lane_addr),
    .lane_en_i  (lane_en),
    .wdata_i    (wdata_i),
    .mask_q_o   (mask_q),
    .mask_nxt_o (mask_nxt)
  );

  lbic_src_sync #(
    .NUM_SRC(NUM_SRC)
  ) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .mask_nxt_i(mask_nxt),
    .src_q_o   (src_q),
    .irq_o     (irq_o)
  );

  assign pend = src_q & mask_q;

  lbic_prio_enc #(
    .NUM_SRC(NUM_SRC)
  ) u_prio (
    .pend_i(pend),
    .vec_o (vec)
  );

  lbic_rd_mux #(
    .NUM_LANES (NUM_LANES),
    .REG_ADDR_W(REG_ADDR_W),
    .VEC_OFS   (VEC_OFS)
  ) u_rd (
    .rd_i       (!we_i),
    .lane_addr_i(lane_addr),
    .lane_en_i  (lane_en),
    .vec_i      (vec),
    .rdata_o    (rdata_o)
  );

endmodule

// File: rtl/lbic_checker.sv
module lbic_checker #(
  parameter int unsigned NUM_SRC    = 16,
  parameter int unsigned BUS_ADDR_W = 16,
  parameter int unsigned REG_ADDR_W = 12,
  parameter int unsigned DATA_W     = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [1:0]            size_i,
  input logic [BUS_ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NUM_SRC-1:0]    irq_i,
  input logic [NUM_SRC-1:0]    mask_q,
  input logic                  irq_o
);

  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  logic byte_rd_vec;
  assign byte_rd_vec = req_i && !we_i && size_i == 2'd0 &&
                       addr_i[REG_ADDR_W-1:0] == '0;

  // R2: output reflects previous-cycle inputs under the current mask
  p_irq_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    irq_o == |($past(irq_i) & mask_q));

  // R3: vector non-zero exactly when the output is raised
  p_vec_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_rd_vec |-> ((rdata_o[7:0] != 8'd0) == irq_o));

  // R3: vector is a multiple of four
  p_vec_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_rd_vec |-> rdata_o[1:0] == 2'b00);

  // R5: mask moves only on a write strobe
  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mask_q));

  // R7: no read strobe, no read data
  p_rdata_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> rdata_o == '0);

  // R7: byte access drives only lane 0
  p_byte_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd0) |-> rdata_o[DATA_W-1:8] == '0);

  // R8: reset holds output and mask clear
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r8: assert (!irq_o && mask_q == '0);
    end
  end

endmodule

bind lbus_irq_ctrl lbic_checker #(
  .NUM_SRC   (NUM_SRC),
  .BUS_ADDR_W(BUS_ADDR_W),
  .REG_ADDR_W(REG_ADDR_W),
  .DATA_W    (DATA_W)
) u_lbic_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .size_i (size_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_i  (irq_i),
  .mask_q (mask_q),
  .irq_o  (irq_o)
);

// File: tb/lbus_irq_ctrl_bench.sv
`timescale 1ns/1ps
module lbus_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq_in = '0;
  logic        irq_out;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_mask = '0;

  always #4 clk = ~clk;

  lbus_irq_ctrl u_lbus_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq_in), .irq_o(irq_out)
  );

  function automatic logic [7:0] vref(logic [15:0] s, logic [15:0] m);
    logic [15:0] p = s & m;
    for (int i = 0; i < 16; i++) if (p[i]) return 8'((i + 1) * 4);
    return 8'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; size = sz; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; size = sz; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic drive_irq(input logic [15:0] v);
    @(negedge clk); irq_in = v;
    @(posedge clk); #1;
  endtask

  task automatic chk_state(input string tag);
    logic [31:0] d;
    rd(16'h0000, 2'd0, d);
    chk(d == {24'd0, vref(irq_in, exp_mask)}, {tag, " vector"}, d, {24'd0, vref(irq_in, exp_mask)});
    chk(irq_out == |(irq_in & exp_mask), {tag, " irq_o"}, irq_out, |(irq_in & exp_mask));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(irq_out == 0, "R8 in reset", irq_out, 0);
    @(negedge clk); rst_ni = 1;
    wr(16'h0002, 2'd0, 32'hFF); wr(16'h0003, 2'd0, 32'hFF); exp_mask = 16'hFFFF;
    drive_irq(16'hFFFF);
    chk(irq_out == 1, "R8 pre-reset raised", irq_out, 1);
    @(negedge clk); rst_ni = 0; #1;
    chk(irq_out == 0, "R8 async clear", irq_out, 0);
    @(negedge clk); rst_ni = 1; exp_mask = '0;
    @(posedge clk); #1;
    chk(irq_out == 0, "R8 mask cleared", irq_out, 0);
    rd(16'h0000, 2'd0, d);
    chk(d == 0, "R8 vector after reset", d, 0);
  endtask

  task automatic t_level;
    wr(16'h0002, 2'd0, 32'hFF); wr(16'h0003, 2'd0, 32'hFF); exp_mask = 16'hFFFF;
    drive_irq(16'h0010);
    chk_state("R1 level high");
    @(negedge clk); irq_in = 16'h0000; #1;
    chk(irq_out == 1, "R2 one-cycle latency", irq_out, 1);
    @(posedge clk); #1;
    chk(irq_out == 0, "R2 follows low", irq_out, 0);
    chk_state("R1 level low");
  endtask

  task automatic t_mask_bytes;
    drive_irq(16'h0100);
    wr(16'h0003, 2'd0, 32'h00); exp_mask = 16'h00FF;
    chk_state("R4 high byte cleared");
    wr(16'h0003, 2'd0, 32'h01); exp_mask = 16'h01FF;
    chk_state("R4 high byte set");
    wr(16'h0002, 2'd0, 32'h00); exp_mask = 16'h0100;
    chk_state("R4 low byte only");
  endtask

  task automatic t_priority;
    logic [15:0] pats [5] = '{16'h8000, 16'h8001, 16'h00F0, 16'hA400, 16'h0003};
    wr(16'h0002, 2'd0, 32'hFF); wr(16'h0003, 2'd0, 32'hFF); exp_mask = 16'hFFFF;
    for (int i = 0; i < 5; i++) begin
      drive_irq(pats[i]);
      chk_state("R3 priority");
    end
    wr(16'h0003, 2'd0, 32'hFB); exp_mask = 16'hFBFF;
    drive_irq(16'hA400);
    chk_state("R3 masked lower source");
  endtask

  task automatic t_half;
    wr(16'h0002, 2'd1, 32'h0000_1234); exp_mask = 16'h1234;
    drive_irq(16'h0205);
    chk_state("R7 halfword mask");
    drive_irq(16'h0001);
    chk_state("R7 halfword masked bit");
  endtask

  task automatic t_word;
    logic [31:0] d;
    wr(16'h0000, 2'd2, 32'hA5C3_FFFF); exp_mask = 16'hA5C3;
    drive_irq(16'h0102);
    rd(16'h0000, 2'd2, d);
    chk(d == {24'd0, vref(irq_in, exp_mask)}, "R7 word read lane0", d, {24'd0, vref(irq_in, exp_mask)});
    rd(16'h0FFD, 2'd3, d);
    chk(d == {vref(irq_in, exp_mask), 24'd0}, "R6 wrap read lane3", d, {vref(irq_in, exp_mask), 24'd0});
    wr(16'h0FFF, 2'd2, 32'h7700_0000); exp_mask = 16'hA577;
    chk_state("R6 wrap write lane3");
    rd(16'h0002, 2'd1, d);
    chk(d == 0, "R5 mask not readable", d, 0);
  endtask

  task automatic t_unmapped;
    logic [15:0] offs [7] = '{16'h0000, 16'h0001, 16'h0004, 16'h0005, 16'h07FF, 16'h0FFE, 16'h0010};
    logic [31:0] d;
    wr(16'h0002, 2'd1, 32'h0); exp_mask = '0;
    drive_irq(16'hFFFF);
    for (int i = 0; i < 7; i++) begin
      wr(offs[i], 2'd0, 32'hFF);
      chk(irq_out == 0, "R5 write ignored", irq_out, 0);
    end
    wr(16'h0002, 2'd0, 32'h01); exp_mask = 16'h0001;
    for (int i = 1; i < 7; i++) begin
      rd(offs[i], 2'd0, d);
      chk(d == 0, "R5 reads zero", d, 0);
    end
    chk_state("R5 vector intact");
  endtask

  task automatic t_alias;
    logic [31:0] d;
    wr(16'h1002, 2'd0, 32'h08); exp_mask = 16'h0008;
    drive_irq(16'h00F8);
    rd(16'hF000, 2'd0, d);
    chk(d == 32'd16, "R6 upper bits ignored", d, 32'd16);
    chk(irq_out == 1, "R6 alias irq", irq_out, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_level();
    t_mask_bytes();
    t_priority();
    t_half();
    t_word();
    t_unmapped();
    t_alias();
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule